// File: doc/BRIEF.md
# DDR Read Data Strobe Generator

This block is the device-side output stage of a high-speed dual-data-rate read path for an embedded flash card interface. It drives an 8-bit data bus together with a forwarded data strobe. During a read burst it takes bytes from an internal read buffer through a valid/ready handshake. Each byte is placed on the bus in the same register update that toggles the strobe, so one strobe period carries two bytes: one on the rising edge and one on the falling edge.

The block also sends short single-edge tokens, such as CRC status or command responses in enhanced-strobe operation. A token is sent one bit per strobe period on data line 0. The bit is valid at the rising strobe edge and is held unchanged through the falling edge. Every burst is framed by a preamble and a postamble during which the strobe stays low with the output enable asserted.

The block runs on an internal clock at twice the device clock, so one strobe period equals two internal cycles. Strobe mode is entered only when it is enabled and the bus is configured to its full 8-bit width.

Top module: `ddr_strobe_tx`

## Requirements
- R1: During a continuous data burst the strobe toggles once per accepted byte, so a strobe period spans two `clk2x` cycles (one device clock period).
- R2: Each accepted byte appears on `dat_o` in the same cycle that the strobe toggles. Bytes go out in acceptance order, and the first byte of a burst sits on a rising edge. A burst has an even number of bytes, so its last byte sits on a falling edge.
- R3: A token of `TOK_LEN` bits is sent MSB first on `dat_o[0]`, with `dat_o[7:1]` held at 0. Each bit appears together with a rising strobe edge and stays unchanged through the following falling edge.
- R4: Outside a burst, `ds_o` and `oe_o` are both 0.
- R5: Strobe mode is allowed only when `strobe_en` is 1 and `bus_width` is 2 (8-bit). With code 0 (1-bit) or code 1 (4-bit), or with `strobe_en` at 0, no burst starts: `oe_o`, `ds_o`, `pl_ready` and `st_ready` all stay 0.
- R6: Before the first strobe edge of a burst, `oe_o` is 1 and `ds_o` is 0 for at least 2 `clk2x` cycles.
- R7: From the cycle of the last strobe edge, `ds_o` stays 0 and `oe_o` stays 1 for exactly 4 cycles: a 2-cycle postamble, then one further device clock. After that, `oe_o` drops.
- R8: `pl_ready` is 1 only during the data phase of a data burst. `st_ready` is 1 only while the block is idle and strobe mode is allowed.
- R9: If a token and payload are both pending while the block is idle, the token burst runs first. `pl_ready` stays 0 throughout the token burst, and the data burst starts after the token burst ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Internal clock at twice the device clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_en | input | 1 | Request for dual-edge strobe mode |
| bus_width | input | 2 | Bus width code: 0 = 1-bit, 1 = 4-bit, 2 = 8-bit |
| pl_valid | input | 1 | Payload byte valid |
| pl_data | input | DATA_W | Payload byte |
| pl_last | input | 1 | Marks the last byte of a burst |
| pl_ready | output | 1 | Payload byte accepted on this edge when valid |
| st_valid | input | 1 | Token pending |
| st_word | input | TOK_LEN | Token bits, MSB sent first |
| st_ready | output | 1 | Token accepted on this edge when valid |
| dat_o | output | DATA_W | Data bus output |
| ds_o | output | 1 | Forwarded data strobe |
| oe_o | output | 1 | Output enable for the data bus and the strobe |

## Verification
A token request and a payload request can arrive on the same idle edge, and only one of them may start a burst. The bench raises `st_valid` and `pl_valid` together while the block is idle. It then checks that the token bits come out first on data line 0 and that `pl_ready` stays low for the whole token burst, including its preamble and postamble. It finally checks that the held payload burst follows with correct bytes, strobe parity and framing.

// File: rtl/ds_strobe_pkg.sv
package ds_strobe_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_DATA,
        S_TOK,
        S_POST,
        S_TAIL
    } ds_state_e;

    localparam logic [1:0] BW_CODE_FULL = 2'd2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic strobe_allowed(input logic en, input logic [1:0] bw);
        return en && (bw == BW_CODE_FULL);
    endfunction

endpackage

// File: rtl/ds_tok_shift.sv
module ds_tok_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] word_i,
    output logic         bit_o
);
    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else if (load) begin
            sh <= word_i;
        end else if (adv) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign bit_o = sh[W-1];
endmodule

// File: rtl/ds_burst_fsm.sv
module ds_burst_fsm
    import ds_strobe_pkg::*;
#(
    parameter int TOK_LEN     = 8,
    parameter int PRE_HALVES  = 2,
    parameter int POST_HALVES = 2,
    parameter int TAIL_HALVES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_ok,
    input  logic pl_valid,
    input  logic pl_last,
    input  logic st_valid,
    output logic ds,
    output logic oe,
    output logic pl_ready,
    output logic st_ready,
    output logic beat_fire,
    output logic tok_adv,
    output logic idle
);
    localparam int CNT_MAX = imax(imax(2 * TOK_LEN, PRE_HALVES),
                                  imax(POST_HALVES, TAIL_HALVES));
    localparam int CW = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] PRE_LD  = CW'(PRE_HALVES - 1);
    localparam logic [CW-1:0] POST_LD = CW'(POST_HALVES - 1);
    localparam logic [CW-1:0] TAIL_LD = CW'(TAIL_HALVES - 1);
    localparam logic [CW-1:0] TOK_LD  = CW'(2 * TOK_LEN - 1);

    ds_state_e     st;
    logic [CW-1:0] cnt;
    logic          tok_kind;

    assign idle      = (st == S_IDLE);
    assign pl_ready  = (st == S_DATA);
    assign st_ready  = idle && mode_ok;
    assign beat_fire = pl_ready && pl_valid;
    assign tok_adv   = (st == S_TOK) && !ds;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            cnt      <= '0;
            ds       <= 1'b0;
            oe       <= 1'b0;
            tok_kind <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    ds <= 1'b0;
                    if (mode_ok && (st_valid || pl_valid)) begin
                        st       <= S_PRE;
                        cnt      <= PRE_LD;
                        oe       <= 1'b1;
                        tok_kind <= st_valid;
                    end
                end
                S_PRE: begin
                    if (cnt == '0) begin
                        st  <= tok_kind ? S_TOK : S_DATA;
                        cnt <= TOK_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_DATA: begin
                    if (beat_fire) begin
                        ds <= ~ds;
                        if (pl_last) begin
                            st  <= S_POST;
                            cnt <= POST_LD;
                        end
                    end
                end
                S_TOK: begin
                    ds <= ~ds;
                    if (cnt == '0) begin
                        st  <= S_POST;
                        cnt <= POST_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_POST: begin
                    ds <= 1'b0;
                    if (cnt == '0) begin
                        st  <= S_TAIL;
                        cnt <= TAIL_LD;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                S_TAIL: begin
                    if (cnt == '0) begin
                        st <= S_IDLE;
                        oe <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R4: idle means a quiet strobe and released outputs
    assert_ds_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE) |-> (!ds && !oe));

    // R5: a refused mode never leaves idle
    assert_refuse_R5: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !mode_ok) |=> (st == S_IDLE));

    // R7: framing after the last edge keeps the strobe low, outputs driven
    assert_post_low_R7: assert property (@(posedge clk) disable iff (rst)
        (st == S_POST || st == S_TAIL) |-> (!ds && oe));

    // R2: the last byte must land on a falling edge
    assert_even_burst_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && pl_last) |-> ds);

    // R9: a pending token wins over pending payload
    assert_tok_first_R9: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && mode_ok && st_valid) |=> (st == S_PRE && tok_kind));

    // R8: payload is only taken while the strobe is driven
    assert_ready_oe_R8: assert property (@(posedge clk) disable iff (rst)
        pl_ready |-> oe);
endmodule

// File: rtl/ddr_strobe_tx.sv
module ddr_strobe_tx
    import ds_strobe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int TOK_LEN     = 8,
    parameter int PRE_HALVES  = 2,
    parameter int POST_HALVES = 2,
    parameter int TAIL_HALVES = 2
) (
    input  logic               clk2x,
    input  logic               rst,
    input  logic               strobe_en,
    input  logic [1:0]         bus_width,
    input  logic               pl_valid,
    input  logic [DATA_W-1:0]  pl_data,
    input  logic               pl_last,
    output logic               pl_ready,
    input  logic               st_valid,
    input  logic [TOK_LEN-1:0] st_word,
    output logic               st_ready,
    output logic [DATA_W-1:0]  dat_o,
    output logic               ds_o,
    output logic               oe_o
);
    logic mode_ok;
    logic beat_fire;
    logic tok_adv;
    logic tok_bit;
    logic fsm_idle;
    logic tok_load;

    assign mode_ok  = strobe_allowed(strobe_en, bus_width);
    assign tok_load = st_ready && st_valid;

    ds_burst_fsm #(
        .TOK_LEN    (TOK_LEN),
        .PRE_HALVES (PRE_HALVES),
        .POST_HALVES(POST_HALVES),
        .TAIL_HALVES(TAIL_HALVES)
    ) u_fsm (
        .clk      (clk2x),
        .rst      (rst),
        .mode_ok  (mode_ok),
        .pl_valid (pl_valid),
        .pl_last  (pl_last),
        .st_valid (st_valid),
        .ds       (ds_o),
        .oe       (oe_o),
        .pl_ready (pl_ready),
        .st_ready (st_ready),
        .beat_fire(beat_fire),
        .tok_adv  (tok_adv),
        .idle     (fsm_idle)
    );

    ds_tok_shift #(.W(TOK_LEN)) u_tok (
        .clk   (clk2x),
        .rst   (rst),
        .load  (tok_load),
        .adv   (tok_adv),
        .word_i(st_word),
        .bit_o (tok_bit)
    );

    always_ff @(posedge clk2x) begin
        if (rst) begin
            dat_o <= '0;
        end else if (beat_fire) begin
            dat_o <= pl_data;
        end else if (tok_adv) begin
            dat_o <= {{(DATA_W-1){1'b0}}, tok_bit};
        end else if (fsm_idle) begin
            dat_o <= '0;
        end
    end

    // R2: an accepted byte and a strobe edge appear together
    assert_beat_edge_R2: assert property (@(posedge clk2x) disable iff (rst)
        beat_fire |=> ((ds_o != $past(ds_o)) && (dat_o == $past(pl_data))));

    // R3: a token bit is presented with a rising strobe edge
    assert_tok_rise_R3: assert property (@(posedge clk2x) disable iff (rst)
        tok_adv |=> (ds_o && dat_o[0] == $past(tok_bit)));

    // R3: a falling edge that carries no byte leaves the bus unchanged
    assert_tok_fall_R3: assert property (@(posedge clk2x) disable iff (rst)
        ($fell(ds_o) && !$past(beat_fire)) |-> $stable(dat_o));
endmodule

// File: tb/ddr_strobe_tx_tb.sv
module ddr_strobe_tx_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       strobe_en;
    logic [1:0] bus_width;
    logic       pl_valid;
    logic [7:0] pl_data;
    logic       pl_last;
    logic       pl_ready;
    logic       st_valid;
    logic [7:0] st_word;
    logic       st_ready;
    logic [7:0] dat_o;
    logic       ds_o;
    logic       oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ddr_strobe_tx u_dut (
        .clk2x(clk), .rst(rst), .strobe_en(strobe_en), .bus_width(bus_width),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_last(pl_last), .pl_ready(pl_ready),
        .st_valid(st_valid), .st_word(st_word), .st_ready(st_ready),
        .dat_o(dat_o), .ds_o(ds_o), .oe_o(oe_o)
    );

    // {is_token, strobe_en, bus_width[1:0], length[7:0], seed[7:0]}
    localparam int NV = 8;
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 1'b1, 2'd2, 8'd2,  8'h11},
        {1'b0, 1'b1, 2'd2, 8'd6,  8'hA0},
        {1'b1, 1'b1, 2'd2, 8'd0,  8'hB4},
        {1'b0, 1'b1, 2'd1, 8'd4,  8'h22},
        {1'b0, 1'b1, 2'd0, 8'd4,  8'h33},
        {1'b1, 1'b0, 2'd2, 8'd0,  8'h5A},
        {1'b0, 1'b1, 2'd2, 8'd16, 8'hF8},
        {1'b1, 1'b1, 2'd2, 8'd0,  8'h01}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic post_and_idle();
        int post = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (!oe_o) break;
            chk(ds_o == 1'b0, "R7", "ds low in postamble", ds_o, 0);
            post++;
        end
        // the cycle of the last edge already counted as one of the four
        chk(post == 3, "R7", "cycles of oe after last edge", post + 1, 4);
        chk(!ds_o && !oe_o && !pl_ready, "R4", "quiet after burst",
            {ds_o, oe_o, pl_ready}, 0);
    endtask

    task automatic run_data(input int n, input logic [7:0] seed);
        int  i = 0;
        int  c = 0;
        int  pre = 0;
        bit  got = 0;
        @(negedge clk);
        pl_valid = 1'b1;
        pl_data  = seed;
        pl_last  = (n == 1);
        while (i < n && c < 200) begin
            @(negedge clk);
            c++;
            if (got) begin
                chk(dat_o == 8'(seed + i), "R2", "byte on bus", dat_o, 8'(seed + i));
                chk(ds_o == ((i % 2) == 0), "R1", "strobe level per beat", ds_o, (i % 2) == 0);
                chk(oe_o, "R8", "oe during beats", oe_o, 1);
                i++;
                if (i == n) begin
                    pl_valid = 1'b0;
                    pl_last  = 1'b0;
                end else begin
                    pl_data = 8'(seed + i);
                    pl_last = (i == n - 1);
                end
            end else if (oe_o && !ds_o) begin
                pre++;
            end
            got = pl_ready && pl_valid;
        end
        chk(i == n, "R2", "bytes accepted", i, n);
        chk(pre >= 2, "R6", "preamble cycles", pre, 2);
        post_and_idle();
    endtask

    task automatic run_tok(input logic [7:0] w, input bit with_data, input logic [7:0] dseed);
        @(negedge clk);
        st_valid = 1'b1;
        st_word  = w;
        if (with_data) begin
            pl_valid = 1'b1;
            pl_data  = dseed;
            pl_last  = 1'b0;
        end
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            st_valid = 1'b0;
            chk(oe_o && !ds_o, "R6", "token preamble", {oe_o, ds_o}, 2'b10);
            chk(!pl_ready, "R9", "payload held during token", pl_ready, 0);
        end
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            chk(ds_o, "R3", "rising edge for token bit", ds_o, 1);
            chk(dat_o == {7'b0, w[7-j]}, "R3", "token bit", dat_o, {7'b0, w[7-j]});
            chk(!pl_ready, "R9", "payload held during token", pl_ready, 0);
            @(negedge clk);
            chk(!ds_o, "R3", "falling edge", ds_o, 0);
            chk(dat_o[0] == w[7-j], "R3", "bit held on falling edge", dat_o[0], w[7-j]);
        end
        post_and_idle();
    endtask

    task automatic run_refuse();
        bit quiet = 1;
        @(negedge clk);
        pl_valid = 1'b1;
        pl_last  = 1'b0;
        st_valid = 1'b1;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            if (oe_o || ds_o || pl_ready || st_ready) quiet = 0;
        end
        chk(quiet, "R5", "no burst when mode refused",
            {oe_o, ds_o, pl_ready, st_ready}, 0);
        pl_valid = 1'b0;
        st_valid = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual 0 expected 1");
        finish_run();
    end

    initial begin
        rst       = 1'b1;
        strobe_en = 1'b1;
        bus_width = 2'd2;
        pl_valid  = 1'b0;
        pl_data   = '0;
        pl_last   = 1'b0;
        st_valid  = 1'b0;
        st_word   = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!oe_o && !ds_o && dat_o == 8'h00, "R4", "reset state",
            {oe_o, ds_o, dat_o}, 0);
        chk(!pl_ready && st_ready, "R8", "ready flags after reset",
            {pl_ready, st_ready}, 2'b01);

        for (int v = 0; v < NV; v++) begin
            strobe_en = VEC[v][18];
            bus_width = VEC[v][17:16];
            @(negedge clk);
            if (!(VEC[v][18] && VEC[v][17:16] == 2'd2))
                run_refuse();
            else if (VEC[v][19])
                run_tok(VEC[v][7:0], 1'b0, 8'h00);
            else
                run_data(int'(VEC[v][15:8]), VEC[v][7:0]);
            repeat (2) @(negedge clk);
        end

        // R9: token and payload requested on the same idle edge
        strobe_en = 1'b1;
        bus_width = 2'd2;
        @(negedge clk);
        run_tok(8'hC3, 1'b1, 8'h40);
        run_data(4, 8'h40);

        // R5: widening the bus after a refusal re-enables strobe mode
        bus_width = 2'd1;
        run_refuse();
        bus_width = 2'd2;
        @(negedge clk);
        chk(st_ready, "R8", "token ready once width is full", st_ready, 1);
        run_data(2, 8'h7E);

        finish_run();
    end
endmodule